// File: doc/BRIEF.md
# Keyed Watchdog With Reset-Out Pulse

This block is a one-shot-armed watchdog for a small 8-bit controller. It stays idle after a hardware reset. Software starts it by writing a two-byte unlock code, 0x1E followed at once by 0xE1, into a write-only key register. Once running, a 14-bit counter advances on each machine-cycle enable. Software must repeat the same two-byte code before the counter reaches its last value, and the code sets the count back to zero. Software has no way to stop the watchdog. Only a hardware reset or the watchdog's own expiry returns it to the idle state.

When the count expires, the block raises a one-cycle expiry flag and returns itself to the disarmed state. On the following clock it starts a reset-out pulse that lasts a fixed number of oscillator periods, 98 by default. A suppress input blocks the pulse without blocking the flag. Counting stops in power-down. During idle, the count either continues or freezes, depending on a hold-in-idle input.

The block is built from three state machines. The key sequencer has the states KS_WAIT and KS_HALF. A write of the first key byte moves it from KS_WAIT to KS_HALF. Any write made in KS_HALF returns it to KS_WAIT, and a write of 0xE1 in KS_HALF also produces a valid-key pulse. The arm controller has the states WD_DISARMED and WD_ARMED. A valid key moves it from WD_DISARMED to WD_ARMED. An expiry moves it from WD_ARMED back to WD_DISARMED. A valid key in WD_ARMED clears the count. The pulse timer has the states RP_QUIET and RP_DRIVE. It moves from RP_QUIET to RP_DRIVE on an unsuppressed expiry, and from RP_DRIVE back to RP_QUIET when its down-count reaches zero.

Top module: `keyed_watchdog`

## Requirements
- R1: While reset is held, and after its release with no key written, `rst_out` and `wdt_expired` stay 0 (the watchdog starts disarmed).
- R2: A write of 0x1E to the key port followed by the next write of 0xE1 arms the watchdog, and its count starts from zero.
- R3: A key write other than 0xE1 directly after 0x1E cancels the sequence (0x1E,0x1E,0xE1 and 0x1E,0x00,0xE1 do not arm), so no expiry follows however long the count enable runs.
- R4: When armed, `wdt_expired` pulses high for exactly one clock in the cycle after the edge that applies the 16383rd counting tick since the count was last zeroed.
- R5: While armed, the 0x1E,0xE1 pair zeroes the count. A valid key on the same edge as the expiring tick wins, and no expiry happens on that edge.
- R6: While armed, key writes that are not the valid pair do not stop or clear the count, so expiry still occurs on schedule.
- R7: An expiry disarms the watchdog. Without a new key, no further expiry occurs.
- R8: Unless suppressed, `rst_out` goes high on the clock after `wdt_expired` and stays high for exactly 98 oscillator cycles.
- R9: With `rst_out_suppress` = 1 on the edge where `wdt_expired` is high, no reset pulse is produced, and `wdt_expired` is still raised.
- R10: A counting tick needs `mc_tick` = 1 and `pwr_down` = 0. Cycles with either condition not met do not advance the count.
- R11: With `idle_mode` = 1, the count advances only when `idle_hold` = 0. With `idle_hold` = 1, idle cycles are frozen and counting resumes on idle exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_tick | input | 1 | Machine-cycle enable, one clock per machine cycle |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key register write data |
| idle_mode | input | 1 | CPU idle indication |
| pwr_down | input | 1 | Power-down indication |
| idle_hold | input | 1 | 1 freezes the count during idle |
| rst_out_suppress | input | 1 | 1 blocks the reset-out pulse |
| rst_out | output | 1 | Reset-out pulse, active high |
| wdt_expired | output | 1 | One-clock expiry flag |

## Verification
The bench covers four conditions. A steady count enable tests the exact 16383-tick expiry point and the pulse length. A sparse random enable mixed with power-down and idle tests the tick gating, and it separates a freeze from a reset of the count, because expiry lands only when the total of qualified ticks is reached. Broken and interleaved key sequences, including junk writes while the watchdog is armed, separate a cancelled sequence from a valid service. A directed service on the very edge of expiry, followed by long runs after an expiry or with the suppress input set, checks that a valid key wins on that edge, that an expiry disarms the watchdog, and that suppression blocks the pulse but not the flag.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    typedef enum logic {KS_WAIT, KS_HALF} kwd_key_e;
    typedef enum logic {WD_DISARMED, WD_ARMED} kwd_arm_e;
    typedef enum logic {RP_QUIET, RP_DRIVE} kwd_pulse_e;

    localparam logic [7:0] KWD_KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KWD_KEY_SECOND = 8'hE1;
endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = KWD_KEY_FIRST,
    parameter logic [DATA_W-1:0] KEY_SECOND = KWD_KEY_SECOND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_ok
);
    kwd_key_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_WAIT;
        else        st_q <= st_d;
    end

    // next state: any write while half-way ends the attempt
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (st_q)
                KS_WAIT: st_d = (wr_data == KEY_FIRST) ? KS_HALF : KS_WAIT;
                KS_HALF: st_d = KS_WAIT;
                default: st_d = KS_WAIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        key_ok = wr_en && (st_q == KS_HALF) && (wr_data == KEY_SECOND);
    end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_ok,
    input  logic tick,
    output logic expired
);
    localparam logic [CNT_W-1:0] TOP_VAL   = '1;
    localparam logic [CNT_W-1:0] LAST_STEP = TOP_VAL - CNT_W'(1);

    kwd_arm_e          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              exp_d, exp_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_DISARMED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and count; a valid key outranks a coincident tick
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        exp_d = 1'b0;
        unique case (st_q)
            WD_DISARMED: begin
                cnt_d = '0;
                if (key_ok) st_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (key_ok) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST_STEP) begin
                        st_d  = WD_DISARMED;
                        cnt_d = '0;
                        exp_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                st_d  = WD_DISARMED;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_q <= 1'b0;
        else        exp_q <= exp_d;
    end

    assign expired = exp_q;
endmodule

// File: rtl/kwd_rstpulse.sv
module kwd_rstpulse
    import kwd_pkg::*;
#(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic suppress,
    output logic pulse
);
    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN - 1);

    kwd_pulse_e    st_q, st_d;
    logic [PW-1:0] left_q, left_d;
    logic          pulse_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RP_QUIET;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        unique case (st_q)
            RP_QUIET: begin
                if (trig && !suppress) begin
                    st_d   = RP_DRIVE;
                    left_d = LOAD;
                end
            end
            RP_DRIVE: begin
                if (left_q == '0) st_d = RP_QUIET;
                else              left_d = left_q - PW'(1);
            end
            default: st_d = RP_QUIET;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (st_d == RP_DRIVE);
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int DATA_W    = 8,
    parameter int PULSE_LEN = 98,
    parameter logic [DATA_W-1:0] KEY_FIRST  = KWD_KEY_FIRST,
    parameter logic [DATA_W-1:0] KEY_SECOND = KWD_KEY_SECOND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_wdata,
    input  logic              idle_mode,
    input  logic              pwr_down,
    input  logic              idle_hold,
    input  logic              rst_out_suppress,
    output logic              rst_out,
    output logic              wdt_expired
);
    logic key_ok;
    logic count_tick;

    // qualified tick: machine cycle, not powered down, not frozen by idle
    always_comb begin
        count_tick = mc_tick && !pwr_down && !(idle_mode && idle_hold);
    end

    kwd_keyseq #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_keyseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (key_we),
        .wr_data(key_wdata),
        .key_ok (key_ok)
    );

    kwd_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_ok (key_ok),
        .tick   (count_tick),
        .expired(wdt_expired)
    );

    kwd_rstpulse #(
        .PULSE_LEN(PULSE_LEN)
    ) u_rstpulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (wdt_expired),
        .suppress(rst_out_suppress),
        .pulse   (rst_out)
    );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int PULSE_LEN = 98
) (
    input logic clk,
    input logic rst_n,
    input logic mc_tick,
    input logic idle_mode,
    input logic pwr_down,
    input logic idle_hold,
    input logic rst_out_suppress,
    input logic rst_out,
    input logic wdt_expired
);
    localparam int HW = $clog2(PULSE_LEN + 1) + 1;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_cnt <= '0;
        else if (rst_out) hi_cnt <= hi_cnt + HW'(1);
        else              hi_cnt <= '0;
    end

    // R1: quiet outputs while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!rst_out && !wdt_expired);
        end
    end

    p_expiry_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expired |=> !wdt_expired);

    p_expiry_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expired |-> $past(mc_tick && !pwr_down));

    p_idle_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expired |-> !$past(idle_mode && idle_hold));

    p_pulse_follows_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(wdt_expired));

    p_pulse_not_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> (hi_cnt < HW'(PULSE_LEN)));

    p_pulse_full_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (hi_cnt == HW'(PULSE_LEN)));

    p_suppress_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_expired && rst_out_suppress && !rst_out) |=> !rst_out);
endmodule

bind keyed_watchdog kwd_checker #(.PULSE_LEN(PULSE_LEN)) u_kwd_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mc_tick         (mc_tick),
    .idle_mode       (idle_mode),
    .pwr_down        (pwr_down),
    .idle_hold       (idle_hold),
    .rst_out_suppress(rst_out_suppress),
    .rst_out         (rst_out),
    .wdt_expired     (wdt_expired)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAST_CNT   = 16382;
    localparam int PLEN       = 98;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       key_we = 1'b0;
    logic [7:0] key_wdata = 8'h00;
    logic       idle_mode = 1'b0;
    logic       pwr_down = 1'b0;
    logic       idle_hold = 1'b0;
    logic       rst_out_suppress = 1'b0;
    logic       rst_out;
    logic       wdt_expired;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference state, built from the requirements
    bit m_half = 0, m_armed = 0, m_exp = 0;
    int m_cnt = 0, m_left = 0;
    int hi_run = 0, exp_seen = 0, pulses_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .key_we(key_we),
        .key_wdata(key_wdata), .idle_mode(idle_mode), .pwr_down(pwr_down),
        .idle_hold(idle_hold), .rst_out_suppress(rst_out_suppress),
        .rst_out(rst_out), .wdt_expired(wdt_expired)
    );

    function automatic bit pick(int pct);
        return ($urandom % 100) < pct;
    endfunction

    function automatic logic [7:0] junk_byte();
        logic [7:0] b = 8'($urandom);
        return (b == 8'h1E) ? 8'h00 : b;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit kok, tk, new_exp;
        kok = key_we && m_half && (key_wdata == 8'hE1);
        tk  = mc_tick && !pwr_down && !(idle_mode && idle_hold);
        if (m_left > 0) m_left--;
        else if (m_exp && !rst_out_suppress) m_left = PLEN;
        new_exp = 0;
        if (m_armed) begin
            if (kok) m_cnt = 0;
            else if (tk) begin
                if (m_cnt == LAST_CNT) begin
                    new_exp = 1; m_armed = 0; m_cnt = 0;
                end else m_cnt++;
            end
        end else if (kok) begin
            m_armed = 1; m_cnt = 0;
        end
        if (key_we) m_half = !m_half && (key_wdata == 8'h1E);
        m_exp = new_exp;
    endtask

    task automatic compare();
        check(wdt_expired == m_exp, cur_req, "wdt_expired", wdt_expired, m_exp);
        check(rst_out == (m_left > 0), cur_req, "rst_out", rst_out, m_left > 0);
        if (wdt_expired) exp_seen++;
        if (rst_out) hi_run++;
        else begin
            if (hi_run > 0) begin
                pulses_seen++;
                check(hi_run == PLEN, "R8", "pulse length", hi_run, PLEN);
            end
            hi_run = 0;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic write_key(logic [7:0] d);
        key_we = 1'b1; key_wdata = d;
        step();
        key_we = 1'b0;
    endtask

    task automatic run(int n, int p_mc, int p_idle, int p_pd, int p_junk, bit ih, bit ds);
        for (int i = 0; i < n; i++) begin
            mc_tick = pick(p_mc); idle_mode = pick(p_idle); pwr_down = pick(p_pd);
            idle_hold = ih; rst_out_suppress = ds;
            if (pick(p_junk)) begin key_we = 1'b1; key_wdata = junk_byte(); end
            else key_we = 1'b0;
            step();
        end
        key_we = 1'b0;
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        int e0, p0;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rst_out == 0, "R1", "rst_out in reset", rst_out, 0);
        check(wdt_expired == 0, "R1", "wdt_expired in reset", wdt_expired, 0);
        rst_n = 1'b1;
        run(300, 50, 20, 5, 10, 1'b0, 1'b0);

        // R2 R4 R8 R11: arm, steady ticks, idle with hold=0 still counts
        cur_req = "R2 R4 R11"; e0 = exp_seen; p0 = pulses_seen;
        mc_tick = 1'b1;
        write_key(8'h1E); write_key(8'hE1);
        run(16500, 100, 100, 0, 0, 1'b0, 1'b0);
        check(exp_seen - e0 == 1, "R4", "expiry count", exp_seen - e0, 1);
        check(pulses_seen - p0 == 1, "R8", "pulse count", pulses_seen - p0, 1);

        // R3 R7: broken keys after expiry never arm
        cur_req = "R3 R7"; e0 = exp_seen;
        write_key(8'h1E); write_key(8'h1E); write_key(8'hE1);
        write_key(8'h1E); write_key(8'h00); write_key(8'hE1);
        run(16500, 100, 0, 0, 0, 1'b0, 1'b0);
        check(exp_seen - e0 == 0, "R3", "no expiry without key", exp_seen - e0, 0);

        // R5 R6: junk writes while armed, then service on the expiring edge
        cur_req = "R5 R6"; e0 = exp_seen;
        write_key(8'h1E); write_key(8'hE1);
        run(12000, 100, 0, 0, 2, 1'b0, 1'b0);
        write_key(8'h1E); write_key(8'hE1);
        mc_tick = 1'b1;
        while (m_cnt != LAST_CNT - 1 && m_armed) step();
        write_key(8'h1E);
        write_key(8'hE1);   // coincides with the expiring tick: key wins
        check(wdt_expired == 0, "R5", "key beats tick", wdt_expired, 0);
        run(16500, 100, 0, 0, 1, 1'b0, 1'b0);
        check(exp_seen - e0 == 1, "R6", "expiry after junk", exp_seen - e0, 1);

        // R10: sparse machine-cycle enable
        cur_req = "R10"; e0 = exp_seen;
        write_key(8'h1E); write_key(8'hE1);
        run(30000, 60, 0, 0, 0, 1'b0, 1'b0);
        check(exp_seen - e0 == 1, "R10", "expiry with sparse tick", exp_seen - e0, 1);

        // R10 R11: idle freeze and power-down
        cur_req = "R10 R11"; e0 = exp_seen;
        write_key(8'h1E); write_key(8'hE1);
        run(40000, 100, 50, 10, 0, 1'b1, 1'b0);
        check(exp_seen - e0 == 1, "R11", "expiry with idle hold", exp_seen - e0, 1);

        // R9: suppressed reset-out
        cur_req = "R9"; e0 = exp_seen; p0 = pulses_seen;
        mc_tick = 1'b1; idle_mode = 1'b0; pwr_down = 1'b0;
        write_key(8'h1E); write_key(8'hE1);
        run(16500, 100, 0, 0, 0, 1'b0, 1'b1);
        check(exp_seen - e0 == 1, "R9", "flag still raised", exp_seen - e0, 1);
        check(pulses_seen - p0 == 0, "R9", "no pulse", pulses_seen - p0, 0);

        finish_up();
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual unfinished expected finished");
            finish_up();
        end
    end
endmodule